// File: doc/BRIEF.md
# Word-Addressed Effective Address Sequencer

This block forms operand effective addresses for a small accumulator-style processor core whose memory word, data bus, index registers and address bus are all the same width (32 bits by default). Because an address always fits in one word, the direct page covers the entire address space. Page carries and page wraps therefore do not exist, and every pointer is read from memory in one access.

The core pulses `start` with an addressing-mode code, the single operand word, and the current X, Y, direct-page base and stack pointer values. Modes that need no memory read return their address one cycle later. Indirect modes issue one read on a simple request/valid port, wait as long as memory needs, and then return the address. Stack modes also return the updated stack pointer, which the core writes back.

Top module: `ea_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `err` are all 0.
- R2: Mode codes 0, 1 and 2 return `dp+op`, `dp+op+x` and `dp+op+y` respectively. `done` goes high in the cycle after `start` is accepted, and no memory read is issued.
- R3: Mode codes 6 and 7 return `op+x` and `op+y` respectively, with no direct-page base added. `done` follows one cycle after `start`.
- R4: Mode code 3 issues exactly one read at `dp+op` and returns the word that was read.
- R5: Mode code 4 issues exactly one read at `dp+op` and returns the word that was read plus Y. Y is sampled when `start` is accepted.
- R6: Mode code 5 issues exactly one read at `dp+op+x` and returns the word that was read.
- R7: Mode code 8 (push) returns the current SP as the address and `sp_new = sp-1`. `done` follows one cycle after `start`.
- R8: Mode code 9 (pull) returns `sp+1` both as the address and as `sp_new`.
- R9: All address sums are modulo 2^32, and any carry out of the top bit is dropped.
- R10: Mode codes 10 to 15 return the raw operand as the address and raise `err` in the same cycle as `done`. `err` is 0 on every other `done`.
- R11: `start` is ignored while `busy` is high. The operation in progress completes with its own result and produces only one `done`.
- R12: `mem_rd` is a single-cycle pulse. For indirect modes, `done` is a single-cycle pulse in the cycle after `mem_valid` is seen, for any memory latency. In modes other than 8 and 9, `sp_new` equals the SP sampled at `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted while idle |
| mode | input | 4 | Addressing-mode code |
| operand | input | W | Operand word |
| x_val | input | W | X index register value |
| y_val | input | W | Y index register value |
| dp_val | input | W | Direct-page base register value |
| sp_val | input | W | Stack pointer value |
| busy | output | 1 | High while an indirect request is outstanding |
| mem_rd | output | 1 | One-cycle pointer read request |
| mem_addr | output | W | Pointer read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data word |
| done | output | 1 | Result strobe |
| ea | output | W | Effective address, valid with done |
| sp_new | output | W | Updated stack pointer, valid with done |
| err | output | 1 | Unknown mode flag, valid with done |

## Verification
The bench builds the block with the default width of 32. This lets it choose operand, base and index values whose sums cross 2^32, so the modulo behaviour and the missing page wrap can be observed at the ports. Its memory model has a latency parameter that the bench changes between zero and several cycles. This covers both a same-cycle response and a long stall, during which a second `start` arrives and Y changes.

// File: rtl/ea_seq.sv
module ea_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   mode,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] x_val,
  input  logic [W-1:0] y_val,
  input  logic [W-1:0] dp_val,
  input  logic [W-1:0] sp_val,
  output logic         busy,
  output logic         mem_rd,
  output logic [W-1:0] mem_addr,
  input  logic         mem_valid,
  input  logic [W-1:0] mem_rdata,
  output logic         done,
  output logic [W-1:0] ea,
  output logic [W-1:0] sp_new,
  output logic         err
);
  localparam logic [3:0] M_DP = 4'd0, M_DPX = 4'd1, M_DPY = 4'd2, M_DPI = 4'd3,
                         M_DPIY = 4'd4, M_DPXI = 4'd5, M_ABX = 4'd6, M_ABY = 4'd7,
                         M_PUSH = 4'd8, M_PULL = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t state;

  wire [W-1:0] dp_base = dp_val + operand;
  wire [W-1:0] sp_inc  = sp_val + 1'b1;

  logic [W-1:0] imm_ea, imm_sp, ptr_addr;
  logic         indir, add_y, bad;
  logic [W-1:0] y_off;

  always_comb begin
    imm_ea   = operand;
    imm_sp   = sp_val;
    ptr_addr = dp_base;
    indir    = 1'b0;
    add_y    = 1'b0;
    bad      = 1'b0;
    case (mode)
      M_DP:   imm_ea = dp_base;
      M_DPX:  imm_ea = dp_base + x_val;
      M_DPY:  imm_ea = dp_base + y_val;
      M_DPI:  indir = 1'b1;
      M_DPIY: begin indir = 1'b1; add_y = 1'b1; end
      M_DPXI: begin indir = 1'b1; ptr_addr = dp_base + x_val; end
      M_ABX:  imm_ea = operand + x_val;
      M_ABY:  imm_ea = operand + y_val;
      M_PUSH: begin imm_ea = sp_val; imm_sp = sp_val - 1'b1; end
      M_PULL: begin imm_ea = sp_inc; imm_sp = sp_inc; end
      default: bad = 1'b1;
    endcase
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      ea       <= '0;
      sp_new   <= '0;
      err      <= 1'b0;
      y_off    <= '0;
    end else begin
      mem_rd <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          sp_new <= imm_sp;
          if (indir) begin
            mem_addr <= ptr_addr;
            mem_rd   <= 1'b1;
            y_off    <= add_y ? y_val : '0;
            state    <= S_REQ;
          end else begin
            ea   <= imm_ea;
            err  <= bad;
            done <= 1'b1;
          end
        end
        S_REQ, S_WAIT: begin
          if (mem_valid) begin
            ea    <= mem_rdata + y_off;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_seq_chk.sv
module ea_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [3:0]   mode,
  input logic [W-1:0] sp_val,
  input logic         busy,
  input logic         mem_rd,
  input logic         done,
  input logic [W-1:0] ea,
  input logic [W-1:0] sp_new,
  input logic         err
);
  // R2
  direct_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (mode < 4'd3 || (mode > 4'd5 && mode < 4'd10))) |=> (done && !mem_rd));
  // R4
  indir_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode >= 4'd3 && mode <= 4'd5) |=> (mem_rd && !done));
  // R7
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 4'd8) |=> (ea == $past(sp_val) && sp_new == $past(sp_val) - 1'b1));
  // R8
  pull_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 4'd9) |=> (ea == $past(sp_val) + 1'b1 && sp_new == ea));
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R12
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ea_seq ea_seq_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .sp_val(sp_val),
  .busy(busy), .mem_rd(mem_rd), .done(done), .ea(ea), .sp_new(sp_new), .err(err)
);

// File: tb/ea_seq_tb_top.sv
module ea_seq_tb_top;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mem_valid = 1'b0;
  logic [3:0] mode = '0;
  logic [W-1:0] operand = '0, x_val = '0, y_val = '0, dp_val = '0, sp_val = '0, mem_rdata = '0;
  logic busy, mem_rd, done, err;
  logic [W-1:0] mem_addr, ea, sp_new;

  int checks = 0, errors = 0, lat = 0, rd_cnt = 0, done_cnt = 0;
  logic pend = 1'b0;
  int cnt = 0;
  logic [W-1:0] addr_q = '0, last_rd_addr = '0;

  always #2 clk = ~clk;

  ea_seq #(.W(W)) dut_i (.*);

  function automatic logic [W-1:0] memf(logic [W-1:0] a);
    return a * 32'd3 + 32'h1000_0001;
  endfunction

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mem_rd) begin
      pend <= 1'b1; addr_q <= mem_addr; last_rd_addr <= mem_addr; cnt <= lat;
    end else if (pend) begin
      if (cnt == 0) begin mem_valid <= 1'b1; mem_rdata <= memf(addr_q); pend <= 1'b0; end
      else cnt <= cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (mem_rd) rd_cnt++;
    if (done) done_cnt++;
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [3:0] m, logic [W-1:0] op, logic [W-1:0] x,
                        logic [W-1:0] y, logic [W-1:0] dp, logic [W-1:0] sp,
                        logic [W-1:0] exp_ea, logic [W-1:0] exp_sp, logic exp_err,
                        int exp_rd, logic [W-1:0] exp_raddr);
    int rd0, d0, n;
    rd0 = rd_cnt; d0 = done_cnt; n = 1;
    @(negedge clk);
    mode = m; operand = op; x_val = x; y_val = y; dp_val = dp; sp_val = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0; y_val = ~y; sp_val = ~sp;
    while (!done && n < 100) begin @(negedge clk); n++; end
    check({req, " done"}, W'(done), W'(1));
    check({req, " ea"}, ea, exp_ea);
    check({req, " sp_new"}, sp_new, exp_sp);
    check({req, " err"}, W'(err), W'(exp_err));
    if (exp_rd == 0) check({req, " latency"}, W'(n), W'(1));
    @(negedge clk);
    check({req, " done pulse"}, W'(done), W'(0));
    check({req, " reads"}, W'(rd_cnt - rd0), W'(exp_rd));
    check({req, " done count"}, W'(done_cnt - d0), W'(1));
    if (exp_rd != 0) check({req, " read addr"}, last_rd_addr, exp_raddr);
  endtask

  task automatic t_reset();
    check("R1 busy", W'(busy), W'(0));
    check("R1 done", W'(done), W'(0));
    check("R1 mem_rd", W'(mem_rd), W'(0));
    check("R1 err", W'(err), W'(0));
  endtask

  task automatic t_direct();
    run_op("R2 dp",  4'd0, 32'h0000_0100, 32'h5, 32'h7, 32'h2000_0000, 32'h9000, 32'h2000_0100, 32'h9000, 0, 0, 0);
    run_op("R2 dpx", 4'd1, 32'h0000_0100, 32'h5, 32'h7, 32'h2000_0000, 32'h9000, 32'h2000_0105, 32'h9000, 0, 0, 0);
    run_op("R2 dpy", 4'd2, 32'h0000_0100, 32'h5, 32'h7, 32'h2000_0000, 32'h9000, 32'h2000_0107, 32'h9000, 0, 0, 0);
  endtask

  task automatic t_absidx();
    run_op("R3 absx", 4'd6, 32'h0004_0000, 32'h11, 32'h22, 32'h7777_0000, 32'h10, 32'h0004_0011, 32'h10, 0, 0, 0);
    run_op("R3 absy", 4'd7, 32'h0004_0000, 32'h11, 32'h22, 32'h7777_0000, 32'h10, 32'h0004_0022, 32'h10, 0, 0, 0);
  endtask

  task automatic t_indirect();
    lat = 0;
    run_op("R4 dpi lat0", 4'd3, 32'h40, 32'h8, 32'h3, 32'h1000, 32'h500, memf(32'h1040), 32'h500, 0, 1, 32'h1040);
    lat = 4;
    run_op("R5 dpiy", 4'd4, 32'h40, 32'h8, 32'h3, 32'h1000, 32'h500, memf(32'h1040) + 32'h3, 32'h500, 0, 1, 32'h1040);
    lat = 2;
    run_op("R6 dpxi", 4'd5, 32'h40, 32'h8, 32'h3, 32'h1000, 32'h500, memf(32'h1048), 32'h500, 0, 1, 32'h1048);
  endtask

  task automatic t_stack();
    run_op("R7 push", 4'd8, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_8000, 32'h0000_8000, 32'h0000_7FFF, 0, 0, 0);
    run_op("R8 pull", 4'd9, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_7FFF, 32'h0000_8000, 32'h0000_8000, 0, 0, 0);
  endtask

  task automatic t_wrap();
    run_op("R9 dpx wrap", 4'd1, 32'hFFFF_FFF0, 32'h20, 32'h0, 32'h0000_0008, 32'h0, 32'h0000_0018, 32'h0, 0, 0, 0);
    run_op("R9 push wrap", 4'd8, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 0, 0, 0);
    lat = 1;
    run_op("R9 dpxi wrap", 4'd5, 32'hFFFF_FFFF, 32'h2, 32'h0, 32'h1, 32'h0, memf(32'h2), 32'h0, 0, 1, 32'h2);
  endtask

  task automatic t_bad();
    run_op("R10 bad mode", 4'd12, 32'hCAFE_0001, 32'h1, 32'h2, 32'h3, 32'h44, 32'hCAFE_0001, 32'h44, 1, 0, 0);
  endtask

  task automatic t_busy_ignore();
    int d0, r0, n;
    d0 = done_cnt; r0 = rd_cnt; n = 0; lat = 6;
    @(negedge clk);
    mode = 4'd3; operand = 32'h10; dp_val = 32'h300; x_val = 0; y_val = 0; sp_val = 32'h77; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    mode = 4'd0; operand = 32'hDEAD_0000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R11 no early done", W'(done), W'(0));
    while (!done && n < 100) begin @(negedge clk); n++; end
    check("R11 ea of first op", ea, memf(32'h310));
    repeat (3) @(negedge clk);
    check("R11 one done", W'(done_cnt - d0), W'(1));
    check("R11 one read", W'(rd_cnt - r0), W'(1));
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_direct();
    t_absidx();
    t_indirect();
    t_stack();
    t_wrap();
    t_bad();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule